// File: doc/BRIEF.md
# Dual-Socket Interrupt Mode Controller

This block holds one 8-bit global control byte shared by two card sockets, together with the interrupt logic that the byte configures. For each socket it keeps a small set of sticky status-change flags. These flags record card events until the host clears them. The host clears them in one of two ways, selected at run time: a read of that socket's flag register, or a write of 1 to the individual flags.

Each socket's functional interrupt request and its status-change flags reach the host on separate interrupt outputs. Each output signals either as a held level or as a single-clock pulse. A power-down output tells the card-side drivers to stay disabled whenever no card access strobe is active.

Software uses a simple register bus. A write takes effect at the clock edge where the write strobe is sampled. Read data is registered and is valid in the cycle after the read strobe.

Top module: `dual_sock_irq_ctrl`

## Requirements
- R1: After the global reset `rst`, the control byte reads 00h, both flag registers read 0, and `func_irq`, `csc_irq` and `pwr_down` are all low.
- R2: The control byte lives at address 1Eh. Bits 4..0 are read/write. Bits 7..5 always read 0, and writing them has no effect.
- R3: A pulse on `sock_rst[i]` clears only socket i's flags. The control byte keeps its value and is cleared only by `rst`.
- R4: A 1 on `csc_evt` sets the matching sticky flag. Socket A uses bits 3..0 and socket B uses bits 7..4. Socket A's flags read at address 04h and socket B's at 05h, in rdata bits 3..0. A read returns the flag values as they were before any clear caused by that read.
- R5: With control bit 2 = 0, a read of a socket's flag register clears all of that socket's flags. Writes to the flag register have no effect.
- R6: With control bit 2 = 1, writing a 1 to a flag bit clears that bit only. Reads do not clear.
- R7: If an event arrives in the same cycle as a clearing read or write of its flag, the flag stays set.
- R8: With control bit 1 = 1 (level), `csc_irq[i]` is high from one cycle after any flag of socket i is set until one cycle after all of its flags are clear.
- R9: With control bit 1 = 0 (edge), `csc_irq[i]` pulses high for exactly one cycle, one cycle after any flag of socket i newly sets.
- R10: Control bit 3 selects the mode for socket A and bit 4 for socket B (1 = level, 0 = edge). In level mode `func_irq[i]` follows `func_req[i]` one cycle later. In edge mode it gives a one-cycle pulse one cycle after `func_req[i]` rises.
- R11: `pwr_down` is high one cycle after control bit 0 is 1 while `card_access` is low. It is low in the cycle after any cycle in which `card_access` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Global synchronous reset, active high |
| sock_rst | input | 2 | Per-socket flag reset (bit 0 = A, bit 1 = B) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| csc_evt | input | 8 | Status-change event pulses (3..0 = A, 7..4 = B) |
| func_req | input | 2 | Functional interrupt requests from the cards |
| card_access | input | 1 | Active card access strobe |
| func_irq | output | 2 | Functional host interrupts |
| csc_irq | output | 2 | Status-change host interrupts |
| pwr_down | output | 1 | Card output disable while idle in power-down |

## Verification
The assertions check these rules on every cycle:
- a write lands in the control byte on the next edge;
- an event always leaves its flag set;
- a clear-on-read read with no coinciding event empties the flags;
- a level-mode output follows its source;
- an edge-mode output stays quiet when no source bit is new;
- an access strobe always drops power-down.

Only the bench scenarios can show the following:
- reads return pre-clear values;
- the clear mechanism changes at run time;
- the reserved bits are masked;
- the two sockets are isolated under socket reset;
- an edge pulse lasts exactly one cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_SOCK = 2;
  localparam int CTRL_W  = 5;

  // Field order matches the register bit positions (bit 4 down to bit 0)
  typedef struct packed {
    logic [NUM_SOCK-1:0] func_lvl;  // bit 4 = socket B, bit 3 = socket A
    logic                w1c_mode;  // bit 2
    logic                csc_lvl;   // bit 1
    logic                pwr_en;    // bit 0
  } ctrl_t;
endpackage

// File: rtl/irqc_ctrl_reg.sv
module irqc_ctrl_reg
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl
);
  always_ff @(posedge clk) begin
    if (rst)        ctrl <= '0;
    else if (wr_en) ctrl <= ctrl_t'(wdata);
  end

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctrl == $past(wdata)));
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sock_rst,
  input  logic [FLAG_W-1:0] evt,
  input  logic              rd_hit,
  input  logic              wr_hit,
  input  logic [FLAG_W-1:0] wdata,
  input  logic              w1c,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] clr;

  always_comb begin
    if (w1c) clr = wr_hit ? wdata : '0;
    else     clr = rd_hit ? '1 : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || sock_rst) flags <= '0;
    else                 flags <= (flags & ~clr) | evt;
  end

  // R7
  evt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((|evt) && !sock_rst) |=> ((flags & $past(evt)) == $past(evt)));

  // R5
  clr_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !w1c && (evt == '0) && !sock_rst) |=> (flags == '0));
endmodule

// File: rtl/irqc_irq_out.sv
module irqc_irq_out #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lvl_mode,
  input  logic [W-1:0] src,
  output logic         irq
);
  logic [W-1:0] prev;
  logic         fresh;

  assign fresh = |(src & ~prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      irq  <= 1'b0;
    end else begin
      prev <= src;
      irq  <= lvl_mode ? (|src) : fresh;
    end
  end

  // R8
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_mode && (|src)) |=> irq);

  // R9
  edge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!lvl_mode && ((src & ~prev) == '0)) |=> !irq);
endmodule

// File: rtl/dual_sock_irq_ctrl.sv
module dual_sock_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         FLAG_W    = 4,
  parameter logic [7:0] CTRL_ADDR = 8'h1E,
  parameter logic [7:0] FLAG_BASE = 8'h04
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SOCK-1:0]        sock_rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_SOCK*FLAG_W-1:0] csc_evt,
  input  logic [NUM_SOCK-1:0]        func_req,
  input  logic                       card_access,
  output logic [NUM_SOCK-1:0]        func_irq,
  output logic [NUM_SOCK-1:0]        csc_irq,
  output logic                       pwr_down
);
  ctrl_t               ctrl;
  logic                ctrl_hit;
  logic [NUM_SOCK-1:0] flag_hit;
  logic [FLAG_W-1:0]   flags [NUM_SOCK];
  logic [DATA_W-1:0]   rd_mux;
  logic                unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:CTRL_W];
  assign ctrl_hit     = (bus_addr == ADDR_W'(CTRL_ADDR));

  irqc_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr_en (bus_wr && ctrl_hit),
    .wdata (bus_wdata[CTRL_W-1:0]),
    .ctrl  (ctrl)
  );

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    assign flag_hit[s] = (bus_addr == ADDR_W'(FLAG_BASE + s));

    irqc_flag_bank #(.FLAG_W(FLAG_W)) u_flags (
      .clk      (clk),
      .rst      (rst),
      .sock_rst (sock_rst[s]),
      .evt      (csc_evt[s*FLAG_W +: FLAG_W]),
      .rd_hit   (bus_rd && flag_hit[s]),
      .wr_hit   (bus_wr && flag_hit[s]),
      .wdata    (bus_wdata[FLAG_W-1:0]),
      .w1c      (ctrl.w1c_mode),
      .flags    (flags[s])
    );

    irqc_irq_out #(.W(FLAG_W)) u_csc_irq (
      .clk      (clk),
      .rst      (rst),
      .lvl_mode (ctrl.csc_lvl),
      .src      (flags[s]),
      .irq      (csc_irq[s])
    );

    irqc_irq_out #(.W(1)) u_func_irq (
      .clk      (clk),
      .rst      (rst),
      .lvl_mode (ctrl.func_lvl[s]),
      .src      (func_req[s]),
      .irq      (func_irq[s])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit) rd_mux = DATA_W'(ctrl);
    for (int s = 0; s < NUM_SOCK; s++)
      if (flag_hit[s]) rd_mux = DATA_W'(flags[s]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pwr_down  <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      pwr_down <= ctrl.pwr_en && !card_access;
    end
  end

  // R11
  access_wake_chk: assert property (@(posedge clk) disable iff (rst)
    card_access |=> !pwr_down);
endmodule

// File: tb/dual_sock_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dual_sock_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sock_rst = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] csc_evt = '0;
  logic [1:0] func_req = '0;
  logic       card_access = 1'b0;
  logic [1:0] func_irq, csc_irq;
  logic       pwr_down;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  dual_sock_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .sock_rst(sock_rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .csc_evt(csc_evt), .func_req(func_req), .card_access(card_access),
    .func_irq(func_irq), .csc_irq(csc_irq), .pwr_down(pwr_down)
  );

  localparam logic [7:0] A_CTRL = 8'h1E;
  localparam logic [7:0] A_FA   = 8'h04;
  localparam logic [7:0] A_FB   = 8'h05;

  typedef struct packed { logic [7:0] wr; logic [7:0] exp; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'hFF, 8'h1F}, '{8'hE0, 8'h00}, '{8'h15, 8'h15},
    '{8'hAA, 8'h0A}, '{8'h3C, 8'h1C}, '{8'h00, 8'h00}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic evt(logic [7:0] e);
    csc_evt = e;
    @(negedge clk);
    csc_evt = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {3'b0, func_irq, csc_irq, pwr_down}, 8'h00);
    rd(A_CTRL, r); chk("R1 ctrl", r, 8'h00);
    rd(A_FA, r);   chk("R1 flags A", r, 8'h00);

    // R2 table walk
    foreach (VECS[i]) begin
      wr(A_CTRL, VECS[i].wr);
      rd(A_CTRL, r);
      chk("R2 ctrl readback", r, VECS[i].exp);
    end

    // R4 / R9 / R5 : edge csc, clear-on-read
    wr(A_CTRL, 8'h00);
    evt(8'h02);
    chk("R9 no irq yet", {6'b0, csc_irq}, 8'h00);
    @(negedge clk); chk("R9 pulse", {6'b0, csc_irq}, 8'h01);
    @(negedge clk); chk("R9 pulse end", {6'b0, csc_irq}, 8'h00);
    rd(A_FB, r); chk("R4 socket B untouched", r, 8'h00);
    rd(A_FA, r); chk("R4 flag A value", r, 8'h02);
    rd(A_FA, r); chk("R5 cleared by read", r, 8'h00);
    evt(8'h04);
    wr(A_FA, 8'h04);
    rd(A_FA, r); chk("R5 write ignored", r, 8'h04);

    // R8 level csc
    wr(A_CTRL, 8'h02);
    evt(8'h10);
    @(negedge clk); chk("R8 level high", {6'b0, csc_irq}, 8'h02);
    repeat (3) @(negedge clk); chk("R8 level held", {6'b0, csc_irq}, 8'h02);
    rd(A_FB, r); chk("R4 flag B value", r, 8'h01);
    @(negedge clk); chk("R8 level drop", {6'b0, csc_irq}, 8'h00);

    // R6 write-1-to-clear
    wr(A_CTRL, 8'h04);
    evt(8'h03);
    rd(A_FA, r); chk("R6 read", r, 8'h03);
    rd(A_FA, r); chk("R6 read keeps", r, 8'h03);
    wr(A_FA, 8'h01);
    rd(A_FA, r); chk("R6 selective clear", r, 8'h02);

    // R7 event with clearing write
    bus_addr = A_FA; bus_wdata = 8'h02; bus_wr = 1'b1; csc_evt = 8'h02;
    @(negedge clk);
    bus_wr = 1'b0; csc_evt = '0;
    rd(A_FA, r); chk("R7 w1c collision", r, 8'h02);
    wr(A_FA, 8'h02);
    rd(A_FA, r); chk("R6 cleared", r, 8'h00);

    // R7 event with clearing read
    wr(A_CTRL, 8'h00);
    evt(8'h08);
    bus_addr = A_FA; bus_rd = 1'b1; csc_evt = 8'h08;
    @(negedge clk);
    bus_rd = 1'b0; csc_evt = '0;
    chk("R7 read value", bus_rdata, 8'h08);
    rd(A_FA, r); chk("R7 read collision", r, 8'h08);
    rd(A_FA, r); chk("R5 final clear", r, 8'h00);

    // R3 socket reset
    wr(A_CTRL, 8'h05);
    evt(8'h41);
    sock_rst = 2'b10;
    @(negedge clk);
    sock_rst = 2'b00;
    rd(A_FB, r);   chk("R3 B cleared", r, 8'h00);
    rd(A_FA, r);   chk("R3 A kept", r, 8'h01);
    rd(A_CTRL, r); chk("R3 ctrl kept", r, 8'h05);

    // R10 functional modes: A level, B edge
    wr(A_CTRL, 8'h08);
    func_req = 2'b11;
    @(negedge clk); chk("R10 both rise", {6'b0, func_irq}, 8'h03);
    @(negedge clk); chk("R10 B pulse end", {6'b0, func_irq}, 8'h01);
    func_req = 2'b00;
    @(negedge clk); chk("R10 A follows", {6'b0, func_irq}, 8'h00);
    wr(A_CTRL, 8'h10);
    func_req = 2'b11;
    @(negedge clk); chk("R10 swapped rise", {6'b0, func_irq}, 8'h03);
    @(negedge clk); chk("R10 swapped hold", {6'b0, func_irq}, 8'h02);
    func_req = 2'b00;

    // R11 power down
    wr(A_CTRL, 8'h01);
    chk("R11 not yet", {7'b0, pwr_down}, 8'h00);
    @(negedge clk); chk("R11 asserted", {7'b0, pwr_down}, 8'h01);
    card_access = 1'b1;
    @(negedge clk); chk("R11 access wakes", {7'b0, pwr_down}, 8'h00);
    card_access = 1'b0;
    @(negedge clk); chk("R11 reasserted", {7'b0, pwr_down}, 8'h01);

    // R1 global reset clears control
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(A_CTRL, r); chk("R1 ctrl after rst", r, 8'h00);
    chk("R1 pwr after rst", {7'b0, pwr_down}, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule